// File: doc/BRIEF.md
# Data-Space Single-Bit Set, Clear and Test Engine

This block changes or examines one bit of a byte-addressed data store. The store is held inside the block. A sequencer presents one decoded request. The request carries an operation (set, clear or test), a bit index, a byte address, a branch polarity and a displacement byte. The block then runs a read-modify-write over a synchronous single-port memory.

Every operation loads a carry flag with the addressed bit as it was before any change. A test operation leaves memory alone. It reports whether the bit matched the requested polarity, and the sequencer can use that flag to redirect its program flow. The displacement byte passes through untouched next to the branch flag. Target arithmetic belongs to the sequencer.

Requests are taken one at a time. A busy flag covers the whole sequence, and a single-cycle done pulse closes it.

Top module: `bitop_unit`

## Requirements
- R1: A synchronous active-high reset clears carry, br_taken, br_disp, busy and done, returns the sequencer to idle, and sets every memory byte to zero.
- R2: A request is accepted at a rising edge where req_valid is 1, busy is 0 and req_op is not 2'b11. busy is 1 from the following cycle until the cycle after done.
- R3: Operation code 2'b00 (set) writes a 1 into bit req_bit of byte req_addr and leaves the other seven bits of that byte unchanged.
- R4: Operation code 2'b01 (clear) writes a 0 into bit req_bit of byte req_addr and leaves the other seven bits of that byte unchanged.
- R5: On every accepted operation, carry takes the value the addressed bit held before the operation. The new value appears in the third cycle after acceptance, and carry does not change while the block is idle.
- R6: Operation code 2'b10 (test) writes nothing to memory. br_taken becomes 1 when the addressed bit equals req_cond (1 means branch when the bit is 1) and 0 otherwise.
- R7: done is a one-cycle pulse. It is high in the third cycle after acceptance for a test and in the fourth cycle after acceptance for a set or clear.
- R8: Operation code 2'b11 is ignored. No busy or done is raised, and carry, br_taken and memory keep their values.
- R9: br_disp shows the req_disp captured at acceptance. br_taken is cleared at acceptance and stays 0 for set and clear operations.
- R10: A request presented while busy is 1 is not accepted and has no effect on the operation in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 00 set, 01 clear, 10 test, 11 reserved |
| req_bit | input | BIT_W (3) | Bit index inside the byte |
| req_addr | input | ADDR_W (8) | Data byte address |
| req_cond | input | 1 | Test polarity: 1 branches on a set bit, 0 on a clear bit |
| req_disp | input | DISP_W (8) | Branch displacement, passed through |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| carry | output | 1 | Pre-operation value of the addressed bit |
| br_taken | output | 1 | Test condition met |
| br_disp | output | DISP_W (8) | Displacement of the accepted request |

## Verification
The bench builds the block with its default parameters: an 8-bit address, 8-bit bytes and an 8-bit displacement. With these values the full 256-byte store and all eight bit positions are reachable. A random sweep therefore hits the top address 255 and bit 7, and it repeatedly revisits bytes that earlier operations modified. The same defaults make it possible to set a bit that is already set, to clear one that is already clear, to hold a request high across a busy window, and to assert reset in the middle of a sequence.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {
    OP_SET  = 2'b00,
    OP_CLR  = 2'b01,
    OP_TST  = 2'b10,
    OP_NONE = 2'b11
  } bop_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_MOD,
    ST_WR,
    ST_FIN
  } bst_e;
endpackage

// File: rtl/bitop_ram.sv
module bitop_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      rdata <= '0;
    end else if (en) begin
      if (we) cells[addr] <= wdata;
      rdata <= cells[addr];
    end
  end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu #(
  parameter int DATA_W = 8,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] rd_byte,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              make_one,
  input  logic              cond,
  output logic              old_bit,
  output logic [DATA_W-1:0] new_byte,
  output logic              cond_hit
);
  function automatic logic f_pick(input logic [DATA_W-1:0] b, input logic [BIT_W-1:0] i);
    return b[i];
  endfunction

  function automatic logic [DATA_W-1:0] f_modify(input logic [DATA_W-1:0] b,
                                                 input logic [BIT_W-1:0] i,
                                                 input logic v);
    logic [DATA_W-1:0] r;
    r    = b;
    r[i] = v;
    return r;
  endfunction

  always_comb begin
    old_bit  = f_pick(rd_byte, bit_idx);
    new_byte = f_modify(rd_byte, bit_idx, make_one);
    cond_hit = (old_bit == cond);
  end
endmodule

// File: rtl/bitop_seq.sv
module bitop_seq
  import bitop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_op,
  input  logic       is_test,
  output bst_e       state,
  output logic       accept
);
  bst_e nxt;

  always_comb begin
    accept = (state == ST_IDLE) && req_valid && (bop_e'(req_op) != OP_NONE);
    nxt    = state;
    unique case (state)
      ST_IDLE: if (accept) nxt = ST_RD;
      ST_RD:   nxt = ST_MOD;
      ST_MOD:  nxt = is_test ? ST_FIN : ST_WR;
      ST_WR:   nxt = ST_FIN;
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int DISP_W = 8,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [BIT_W-1:0]  req_bit,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_cond,
  input  logic [DISP_W-1:0] req_disp,
  output logic              busy,
  output logic              done,
  output logic              carry,
  output logic              br_taken,
  output logic [DISP_W-1:0] br_disp
);
  bst_e              state;
  logic              accept;
  bop_e              op_q;
  logic [BIT_W-1:0]  bit_q;
  logic [ADDR_W-1:0] addr_q;
  logic              cond_q;
  logic [DISP_W-1:0] disp_q;
  logic              carry_q;
  logic              taken_q;
  logic [DATA_W-1:0] wbyte_q;
  logic [DATA_W-1:0] rd_byte;
  logic              old_bit;
  logic              cond_hit;
  logic [DATA_W-1:0] new_byte;
  logic              ram_en;
  logic              ram_we;
  logic              is_test;

  assign is_test = (op_q == OP_TST);
  assign ram_en  = (state == ST_RD) || (state == ST_WR);
  assign ram_we  = (state == ST_WR);

  bitop_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .is_test   (is_test),
    .state     (state),
    .accept    (accept)
  );

  bitop_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (addr_q),
    .wdata (wbyte_q),
    .rdata (rd_byte)
  );

  bitop_alu #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_alu (
    .rd_byte  (rd_byte),
    .bit_idx  (bit_q),
    .make_one (op_q == OP_SET),
    .cond     (cond_q),
    .old_bit  (old_bit),
    .new_byte (new_byte),
    .cond_hit (cond_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= OP_SET;
      bit_q   <= '0;
      addr_q  <= '0;
      cond_q  <= 1'b0;
      disp_q  <= '0;
      carry_q <= 1'b0;
      taken_q <= 1'b0;
      wbyte_q <= '0;
    end else begin
      if (accept) begin
        op_q    <= bop_e'(req_op);
        bit_q   <= req_bit;
        addr_q  <= req_addr;
        cond_q  <= req_cond;
        disp_q  <= req_disp;
        taken_q <= 1'b0;
      end
      if (state == ST_MOD) begin
        carry_q <= old_bit;
        taken_q <= is_test && cond_hit;
        wbyte_q <= new_byte;
      end
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FIN);
  assign carry    = carry_q;
  assign br_taken = taken_q;
  assign br_disp  = disp_q;
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic              carry,
  input logic              br_taken,
  input logic              ram_we,
  input logic [1:0]        op_q,
  input logic [BIT_W-1:0]  bit_q,
  input logic [DATA_W-1:0] wbyte_q
);
  AST_BUSY_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid)); // R2
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> busy); // R2
  AST_SET_WRITES_ONE: assert property (@(posedge clk) disable iff (rst)
    (ram_we && op_q == 2'b00) |-> wbyte_q[bit_q]); // R3
  AST_CLR_WRITES_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ram_we && op_q == 2'b01) |-> !wbyte_q[bit_q]); // R4
  AST_CARRY_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(carry)); // R5
  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (op_q != 2'b10)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_TAKEN_ONLY_TEST: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (op_q == 2'b10)); // R9
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W), .BIT_W(BIT_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .carry     (carry),
  .br_taken  (br_taken),
  .ram_we    (ram_we),
  .op_q      (op_q),
  .bit_q     (bit_q),
  .wbyte_q   (wbyte_q)
);

// File: tb/test_bitop_unit.sv
`timescale 1ns/1ps
module test_bitop_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [2:0] req_bit = '0;
  logic [7:0] req_addr = '0;
  logic       req_cond = 1'b0;
  logic [7:0] req_disp = '0;
  logic       busy, done, carry, br_taken;
  logic [7:0] br_disp;

  int vectors = 0;
  int errors  = 0;
  bit ended   = 0;

  always #2.5 clk = ~clk;

  bitop_unit i_bitop_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_bit(req_bit), .req_addr(req_addr), .req_cond(req_cond),
    .req_disp(req_disp), .busy(busy), .done(done), .carry(carry),
    .br_taken(br_taken), .br_disp(br_disp)
  );

  // behavioural reference: byte image plus a phase counter since acceptance
  int m_mem [256];
  int m_phase = 0;
  int m_op, m_bit, m_addr, m_cond, m_disp;
  int m_carry = 0, m_taken = 0;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_phase = 0; m_carry = 0; m_taken = 0; m_disp = 0;
    end else if (m_phase == 0) begin
      if (req_valid && req_op != 2'b11) begin
        m_op = req_op; m_bit = req_bit; m_addr = req_addr;
        m_cond = req_cond; m_disp = req_disp; m_taken = 0; m_phase = 1;
      end
    end else if (m_phase == 1) begin
      m_phase = 2;
    end else if (m_phase == 2) begin
      int b;
      b = (m_mem[m_addr] >> m_bit) & 1;
      m_carry = b;
      if (m_op == 2) m_taken = (b == m_cond) ? 1 : 0;
      else if (m_op == 0) m_mem[m_addr] = m_mem[m_addr] | (1 << m_bit);
      else m_mem[m_addr] = m_mem[m_addr] & ~(1 << m_bit) & 255;
      m_phase = 3;
    end else if (m_phase == 3) begin
      m_phase = (m_op == 2) ? 0 : 4;
    end else begin
      m_phase = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!ended) begin
      int exp_done;
      exp_done = ((m_phase == 3 && m_op == 2) || m_phase == 4) ? 1 : 0;
      chk("R2 busy", busy, (m_phase != 0) ? 1 : 0);
      chk("R7 done", done, exp_done);
      chk("R5 carry", carry, m_carry);
      chk("R6 br_taken", br_taken, m_taken);
      chk("R9 br_disp", br_disp, m_disp);
    end
  end

  task automatic drive(input int op, input int b, input int a, input int c, input int d);
    req_op = op[1:0]; req_bit = b[2:0]; req_addr = a[7:0];
    req_cond = c[0]; req_disp = d[7:0];
  endtask

  task automatic run_op(input int op, input int b, input int a, input int c, input int d);
    @(negedge clk);
    drive(op, b, a, c, d);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  // test a bit and return the resulting carry and taken flag
  task automatic probe(input int b, input int a, output int cy, output int tk);
    run_op(2, b, a, 1, 0);
    cy = carry; tk = br_taken;
  endtask

  initial begin
    int cy, tk;
    repeat (3) @(negedge clk);
    chk("R1 carry after reset", carry, 0);
    chk("R1 busy after reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1: memory starts at zero (top address, top bit)
    probe(7, 255, cy, tk);
    chk("R1 mem zero", tk, 0);
    // R6: polarity 0 branches on a clear bit
    run_op(2, 2, 17, 0, 8'h5A);
    chk("R6 cond0 taken", br_taken, 1);
    chk("R9 disp passed", br_disp, 8'h5A);

    // R3: set bit 3 of byte 5, neighbours untouched
    run_op(0, 3, 5, 0, 0);
    chk("R5 carry before set", carry, 0);
    chk("R9 taken zero for set", br_taken, 0);
    probe(3, 5, cy, tk);
    chk("R3 bit set", tk, 1);
    probe(2, 5, cy, tk);
    chk("R3 neighbour clear", tk, 0);
    run_op(0, 3, 5, 0, 0);
    chk("R5 carry old one", carry, 1);

    // R4: clear it again
    run_op(1, 3, 5, 0, 0);
    chk("R4 carry before clear", carry, 1);
    probe(3, 5, cy, tk);
    chk("R4 bit cleared", tk, 0);
    chk("R6 carry from test", cy, 0);

    // R8: reserved op ignored
    run_op(0, 0, 9, 0, 0);
    @(negedge clk);
    drive(3, 0, 9, 0, 8'hEE);
    req_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 no busy", busy, 0);
    req_valid = 1'b0;
    probe(0, 9, cy, tk);
    chk("R8 mem kept", tk, 1);

    // R10: request held during busy, then changed while busy
    @(negedge clk);
    drive(0, 6, 40, 0, 1);
    req_valid = 1'b1;
    @(negedge clk);
    drive(0, 1, 41, 0, 2);
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    probe(1, 41, cy, tk);
    chk("R10 busy request dropped", tk, 0);

    // mid-operation reset
    run_op(0, 4, 77, 0, 0);
    @(negedge clk);
    drive(1, 4, 77, 0, 3);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset aborts", busy, 0);

    // random sweep over a small address window to revisit bytes
    for (int k = 0; k < 400; k++) begin
      run_op($urandom_range(0, 3), $urandom_range(0, 7),
             ($urandom_range(0, 1) != 0) ? $urandom_range(248, 255) : $urandom_range(0, 7),
             $urandom_range(0, 1), $urandom_range(0, 255));
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!ended) begin
      ended = 1;
      errors++;
      vectors++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule